// File: doc/BRIEF.md
# Instruction Cache Tag, Valid and Replacement Controller

This block keeps the tags, valid bits, lock bits and replacement state of an instruction cache. The default geometry is 64 sets of 8 ways with 64-byte blocks, which gives 512 tags and 32 KB. A fetch address is split into a block offset (bits [5:0]), a set index (bits [11:6]) and a tag (bits [31:12]). One cycle after a lookup is accepted, the block reports hit or miss and, on a hit, a one-hot way select. The data array, the memory controller and any instruction decoding lie outside the block.

On a miss the block chooses a victim way with a binary-tree pseudo-LRU and raises a refill request for the whole 64-byte block. It stops taking lookups until the memory side reports that the refill is done. Only then does it write the tag and mark the block valid. A block has a single valid bit, so it is either wholly present or wholly absent. A maintenance port can invalidate a block by address, which is how software keeps the cache coherent. The same port locks or unlocks one of ways 0 to 3 in a set. While any lockable way in a set is locked, replacement in that set is confined to ways 4 to 7, so at most half the cache can be pinned. A constant geometry word reports block size, associativity and set count.

The controller has three states. INIT is entered on reset and clears every set in turn. IDLE accepts lookups and maintenance operations. REFILL waits for refill_done. The transitions are: INIT_DONE (INIT to IDLE, after the last set is cleared), LOOKUP_MISS (IDLE to REFILL), LOOKUP_HIT and MAINT (IDLE to IDLE), and FILL (REFILL to IDLE, on refill_done).

Top module: `icache_tag_ctrl`

## Requirements
- R1: After reset, ready is low for exactly 64 clock cycles (one per set) while every valid bit, lock bit and LRU tree is cleared. Every lookup after that misses until a fill.
- R2: geom_o reports block bytes in bits [23:16] (64), ways in bits [15:8] (8) and sets in bits [7:0] (64). Bits [31:24] are zero, and the product of the three fields is 32768.
- R3: A lookup accepted while ready is high produces hit_valid in the next cycle. A lookup whose tag (addr[31:12]) matches a valid way of set addr[11:6] gives hit=1 and a one-hot hit_way with bit w set for way w. The offset bits have no effect.
- R4: A lookup that misses gives hit=0 in the same cycle that refill_req rises. refill_addr is the lookup address with bits [5:0] cleared, and refill_way is the one-hot victim.
- R5: refill_req stays high until refill_done. The block becomes valid only when refill_done is seen. ready returns high in the cycle after refill_done.
- R6: A lookup presented while ready is low is ignored: it produces no hit_valid pulse and no change of state.
- R7: Each set has a 7-bit tree. Node 0 is the root, and the children of node n are 2n+1 and 2n+2. A node bit of 0 steers the victim to the lower half of the ways. The victim is read from the root down, most significant way bit first. A hit or a fill of way w sets every node on w's path to point away from w.
- R8: The maintenance operation lock (maint_op=1) sets the lock bit of way maint_way (0 to 3) in set maint_addr[11:6]. While any lock bit of a set is set, the root decision is forced to the upper half, so a victim is always one of ways 4 to 7 and locked blocks stay resident.
- R9: The maintenance operation unlock (maint_op=2) clears one lock bit. After that, victim choice follows the plain tree again.
- R10: The maintenance operation invalidate (maint_op=0) clears the valid bit of the way in set maint_addr[11:6] whose tag equals maint_addr[31:12], if there is one. No other block changes. A maintenance request is taken only when ready is high and lookup_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lookup_valid | input | 1 | Fetch lookup request |
| lookup_addr | input | 32 | Fetch byte address |
| maint_valid | input | 1 | Maintenance request |
| maint_op | input | 2 | 0 invalidate, 1 lock, 2 unlock |
| maint_addr | input | 32 | Address selecting set and tag for maintenance |
| maint_way | input | 2 | Lockable way (0 to 3) for lock and unlock |
| refill_done | input | 1 | Memory has delivered the whole block |
| ready | output | 1 | High in IDLE; lookups accepted |
| hit_valid | output | 1 | Lookup result valid this cycle |
| hit | output | 1 | Lookup hit |
| hit_way | output | 8 | One-hot hitting way |
| refill_req | output | 1 | Refill request, held until done |
| refill_addr | output | 32 | Block-aligned refill address |
| refill_way | output | 8 | One-hot victim way being filled |
| geom_o | output | 32 | Constant geometry word |

## Verification
The assertions assume that refill_done arrives only while refill_req is high. They also assume that no tag is ever present twice in one set, which holds as long as blocks are written only after a miss. They assume that lookup and maintenance requests are never raised together. The bench drives every input at falling edges. It pulses refill_done only after it has seen a refill request, and it issues maintenance operations only while ready is high and no lookup is pending, except for the one deliberate lookup made while the controller is busy. A reference model in the bench tracks the tags, valid bits, trees and locks, and predicts every hit, way and victim from the requirements.

// File: rtl/ict_pkg.sv
package ict_pkg;
    typedef enum logic [1:0] {
        ST_INIT   = 2'd0,
        ST_IDLE   = 2'd1,
        ST_REFILL = 2'd2
    } ict_state_e;

    typedef enum logic [1:0] {
        MOP_INVAL  = 2'd0,
        MOP_LOCK   = 2'd1,
        MOP_UNLOCK = 2'd2,
        MOP_NONE   = 2'd3
    } ict_mop_e;
endpackage

// File: rtl/ict_tag_match.sv
module ict_tag_match #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 20
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
    input  logic [WAYS-1:0]            valid_i,
    input  logic [TAG_W-1:0]           tag_i,
    output logic [WAYS-1:0]            match_o,
    output logic                       any_o
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match_o[w] = valid_i[w] && (tags_i[w] == tag_i);
    end
    assign any_o = |match_o;
endmodule

// File: rtl/ict_lru_tree.sv
module ict_lru_tree #(
    parameter int WAYS = 8,
    localparam int IDX_W = $clog2(WAYS)
) (
    input  logic [WAYS-2:0]  tree_i,
    input  logic             lock_any_i,
    input  logic [IDX_W-1:0] touch_way_i,
    output logic [IDX_W-1:0] victim_o,
    output logic [WAYS-2:0]  tree_next_o
);
    // Victim walk: root first, forced upward at the root while locks exist.
    always_comb begin
        int  node;
        logic b;
        node     = 0;
        victim_o = '0;
        for (int l = 0; l < IDX_W; l++) begin
            b = tree_i[node];
            if (l == 0 && lock_any_i) b = 1'b1;
            victim_o[IDX_W-1-l] = b;
            node = 2 * node + 1 + int'(b);
        end
    end

    // Touch: every node on the path points to the other branch.
    always_comb begin
        int  node;
        logic b;
        node        = 0;
        tree_next_o = tree_i;
        for (int l = 0; l < IDX_W; l++) begin
            b = touch_way_i[IDX_W-1-l];
            tree_next_o[node] = ~b;
            node = 2 * node + 1 + int'(b);
        end
    end
endmodule

// File: rtl/icache_tag_ctrl.sv
module icache_tag_ctrl
    import ict_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SETS        = 64,
    parameter int WAYS        = 8,
    parameter int BLOCK_BYTES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lookup_valid,
    input  logic [31:0] lookup_addr,
    input  logic        maint_valid,
    input  logic [1:0]  maint_op,
    input  logic [31:0] maint_addr,
    input  logic [1:0]  maint_way,
    input  logic        refill_done,
    output logic        ready,
    output logic        hit_valid,
    output logic        hit,
    output logic [7:0]  hit_way,
    output logic        refill_req,
    output logic [31:0] refill_addr,
    output logic [7:0]  refill_way,
    output logic [31:0] geom_o
);
    localparam int OFF_W     = $clog2(BLOCK_BYTES);
    localparam int SET_W     = $clog2(SETS);
    localparam int TAG_W     = ADDR_W - SET_W - OFF_W;
    localparam int IDX_W     = $clog2(WAYS);
    localparam int LOCK_WAYS = WAYS / 2;

    // ---------------- address split ----------------
    logic [SET_W-1:0] lk_set, mt_set, rd_set, tree_set;
    logic [TAG_W-1:0] lk_tag, mt_tag, rd_tag;
    assign lk_set = lookup_addr[OFF_W +: SET_W];
    assign lk_tag = lookup_addr[OFF_W+SET_W +: TAG_W];
    assign mt_set = maint_addr[OFF_W +: SET_W];
    assign mt_tag = maint_addr[OFF_W+SET_W +: TAG_W];
    assign rd_set = lookup_valid ? lk_set : mt_set;
    assign rd_tag = lookup_valid ? lk_tag : mt_tag;

    // ---------------- storage ----------------
    logic [TAG_W-1:0]     tag_q   [SETS][WAYS];
    logic [WAYS-1:0]      valid_q [SETS];
    logic [WAYS-2:0]      lru_q   [SETS];
    logic [LOCK_WAYS-1:0] lock_q  [SETS];

    ict_state_e        state_q, state_d;
    logic [SET_W-1:0]  init_cnt_q;
    logic [TAG_W-1:0]  pend_tag_q;
    logic [SET_W-1:0]  pend_set_q;
    logic [IDX_W-1:0]  pend_way_q;
    logic              hit_valid_q, hit_q;
    logic [WAYS-1:0]   hit_way_q;

    // ---------------- tag compare ----------------
    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    logic [WAYS-1:0]            match;
    logic                       rd_hit;
    always_comb begin
        for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[rd_set][w];
    end

    ict_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .tags_i  (set_tags),
        .valid_i (valid_q[rd_set]),
        .tag_i   (rd_tag),
        .match_o (match),
        .any_o   (rd_hit)
    );

    logic [IDX_W-1:0] match_idx;
    always_comb begin
        match_idx = '0;
        for (int w = 0; w < WAYS; w++)
            if (match[w]) match_idx = IDX_W'(w);
    end

    // ---------------- replacement tree ----------------
    logic [IDX_W-1:0] touch_way, victim;
    logic [WAYS-2:0]  tree_next;
    logic             lock_any;
    assign tree_set  = (state_q == ST_REFILL) ? pend_set_q : rd_set;
    assign touch_way = (state_q == ST_REFILL) ? pend_way_q : match_idx;
    assign lock_any  = |lock_q[tree_set];

    ict_lru_tree #(.WAYS(WAYS)) u_lru (
        .tree_i      (lru_q[tree_set]),
        .lock_any_i  (lock_any),
        .touch_way_i (touch_way),
        .victim_o    (victim),
        .tree_next_o (tree_next)
    );

    // ---------------- control decode ----------------
    logic do_lookup, do_maint, do_fill;
    assign do_lookup = (state_q == ST_IDLE) && lookup_valid;
    assign do_maint  = (state_q == ST_IDLE) && !lookup_valid && maint_valid;
    assign do_fill   = (state_q == ST_REFILL) && refill_done;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:   if (init_cnt_q == SET_W'(SETS-1)) state_d = ST_IDLE;
            ST_IDLE:   if (do_lookup && !rd_hit)         state_d = ST_REFILL;
            ST_REFILL: if (refill_done)                  state_d = ST_IDLE;
            default:                                     state_d = ST_INIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    // output and bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_cnt_q  <= '0;
            pend_tag_q  <= '0;
            pend_set_q  <= '0;
            pend_way_q  <= '0;
            hit_valid_q <= 1'b0;
            hit_q       <= 1'b0;
            hit_way_q   <= '0;
        end else begin
            hit_valid_q <= do_lookup;
            hit_q       <= do_lookup && rd_hit;
            hit_way_q   <= (do_lookup && rd_hit) ? match : '0;
            if (state_q == ST_INIT) init_cnt_q <= init_cnt_q + 1'b1;
            if (do_lookup && !rd_hit) begin
                pend_tag_q <= lk_tag;
                pend_set_q <= lk_set;
                pend_way_q <= victim;
            end
        end
    end

    // arrays: cleared by the INIT sweep rather than by reset
    always_ff @(posedge clk) begin
        if (state_q == ST_INIT) begin
            valid_q[init_cnt_q] <= '0;
            lru_q[init_cnt_q]   <= '0;
            lock_q[init_cnt_q]  <= '0;
        end else if (do_fill) begin
            tag_q[pend_set_q][pend_way_q]   <= pend_tag_q;
            valid_q[pend_set_q][pend_way_q] <= 1'b1;
            lru_q[pend_set_q]               <= tree_next;
        end else if (do_lookup && rd_hit) begin
            lru_q[lk_set] <= tree_next;
        end else if (do_maint) begin
            unique case (ict_mop_e'(maint_op))
                MOP_INVAL:  valid_q[mt_set]           <= valid_q[mt_set] & ~match;
                MOP_LOCK:   lock_q[mt_set][maint_way] <= 1'b1;
                MOP_UNLOCK: lock_q[mt_set][maint_way] <= 1'b0;
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    assign ready       = (state_q == ST_IDLE);
    assign hit_valid   = hit_valid_q;
    assign hit         = hit_q;
    assign hit_way     = 8'(hit_way_q);
    assign refill_req  = (state_q == ST_REFILL);
    assign refill_addr = 32'({pend_tag_q, pend_set_q, {OFF_W{1'b0}}});
    assign refill_way  = 8'(1 << pend_way_q);
    assign geom_o      = {8'd0, 8'(BLOCK_BYTES), 8'(WAYS), 8'(SETS)};

    // ---------------- assertions ----------------
    assert_hit_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && hit) |-> $onehot(hit_way));

    assert_match_unique_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> $onehot0(match));

    assert_miss_requests_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !hit) |-> refill_req);

    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && !refill_done) |=> refill_req);

    assert_busy_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && lookup_valid) |=> !hit_valid);

    assert_victim_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (do_lookup && !rd_hit && (|lock_q[lk_set])) |=> (refill_way[LOCK_WAYS-1:0] == '0));

    assert_init_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT) |-> (!hit_valid && !refill_req));
endmodule

// File: tb/icache_tag_ctrl_test.sv
module icache_tag_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lookup_valid = 1'b0;
    logic [31:0] lookup_addr = '0;
    logic        maint_valid = 1'b0;
    logic [1:0]  maint_op = 2'd3;
    logic [31:0] maint_addr = '0;
    logic [1:0]  maint_way = '0;
    logic        refill_done = 1'b0;
    logic        ready, hit_valid, hit, refill_req;
    logic [7:0]  hit_way, refill_way;
    logic [31:0] refill_addr, geom_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    icache_tag_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
        .maint_valid(maint_valid), .maint_op(maint_op),
        .maint_addr(maint_addr), .maint_way(maint_way),
        .refill_done(refill_done),
        .ready(ready), .hit_valid(hit_valid), .hit(hit), .hit_way(hit_way),
        .refill_req(refill_req), .refill_addr(refill_addr),
        .refill_way(refill_way), .geom_o(geom_o)
    );

    // reference model built from the requirements
    bit [19:0] m_tag  [64][8];
    bit [7:0]  m_val  [64];
    bit [6:0]  m_lru  [64];
    bit [3:0]  m_lock [64];

    function automatic int m_victim(int s);
        int b0, b1, b2;
        b0 = (m_lock[s] != 0) ? 1 : int'(m_lru[s][0]);
        b1 = int'(m_lru[s][1 + b0]);
        b2 = int'(m_lru[s][3 + 2*b0 + b1]);
        return 4*b0 + 2*b1 + b2;
    endfunction

    task automatic m_touch(int s, int w);
        int w2, w1, w0;
        w2 = (w >> 2) & 1; w1 = (w >> 1) & 1; w0 = w & 1;
        m_lru[s][0]              = ~w2[0];
        m_lru[s][1 + w2]         = ~w1[0];
        m_lru[s][3 + 2*w2 + w1]  = ~w0[0];
    endtask

    function automatic int m_find(int s, bit [19:0] t);
        for (int w = 0; w < 8; w++)
            if (m_val[s][w] && m_tag[s][w] == t) return w;
        return -1;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit [31:0] mk(bit [19:0] t, int s, int off);
        return {t, 6'(s), 6'(off)};
    endfunction

    // one lookup, checked against the model; miss is refilled after `hold` cycles
    task automatic lookup(bit [31:0] a, int hold);
        int s, w, v;
        bit [19:0] t;
        s = int'(a[11:6]); t = a[31:12];
        w = m_find(s, t);
        v = m_victim(s);
        @(negedge clk); lookup_valid = 1'b1; lookup_addr = a;
        @(negedge clk); lookup_valid = 1'b0;
        chk(hit_valid == 1'b1, "R3 hit_valid", hit_valid, 1);
        if (w >= 0) begin
            chk(hit == 1'b1, "R3 hit", hit, 1);
            chk(hit_way == 8'(1 << w), "R3 hit_way", hit_way, 1 << w);
            m_touch(s, w);
        end else begin
            chk(hit == 1'b0, "R4 miss", hit, 0);
            chk(refill_req == 1'b1, "R4 refill_req", refill_req, 1);
            chk(refill_addr == {a[31:6], 6'd0}, "R4 refill_addr", refill_addr, {a[31:6], 6'd0});
            chk(refill_way == 8'(1 << v), "R7 victim", refill_way, 1 << v);
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                chk(refill_req && !ready, "R5 held", refill_req, 1);
            end
            refill_done = 1'b1;
            @(negedge clk); refill_done = 1'b0;
            chk(ready == 1'b1 && refill_req == 1'b0, "R5 ready back", ready, 1);
            m_tag[s][v] = t; m_val[s][v] = 1'b1; m_touch(s, v);
        end
    endtask

    task automatic maint(bit [1:0] op, bit [31:0] a, bit [1:0] w);
        int s, f;
        s = int'(a[11:6]);
        @(negedge clk); maint_valid = 1'b1; maint_op = op; maint_addr = a; maint_way = w;
        @(negedge clk); maint_valid = 1'b0; maint_op = 2'd3;
        case (op)
            2'd0: begin f = m_find(s, a[31:12]); if (f >= 0) m_val[s][f] = 1'b0; end
            2'd1: m_lock[s][w] = 1'b1;
            2'd2: m_lock[s][w] = 1'b0;
            default: ;
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        for (int s = 0; s < 64; s++) begin m_val[s] = '0; m_lru[s] = '0; m_lock[s] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: init length
        n = 0;
        while (!ready && n < 200) begin @(negedge clk); n++; end
        chk(n == 64, "R1 init cycles", n, 64);
        chk(!hit_valid && !refill_req, "R1 quiet after init", refill_req, 0);
        // R2: geometry word
        chk(geom_o == 32'h0040_0840, "R2 geom", geom_o, 32'h0040_0840);
        chk(geom_o[23:16] * geom_o[15:8] * geom_o[7:0] == 32768, "R2 product",
            geom_o[23:16] * geom_o[15:8] * geom_o[7:0], 32768);

        // R1/R3/R4: sweep every set: miss then hit with other offset
        for (int s = 0; s < 64; s++) begin
            lookup(mk(20'(s + 100), s, s), s % 3);
            lookup(mk(20'(s + 100), s, 63 - s), 0);
        end

        // R7: thrash one set with 12 tags, then revisit
        for (int k = 0; k < 12; k++) lookup(mk(20'(k + 500), 5, 0), 1);
        for (int k = 11; k >= 0; k--) lookup(mk(20'(k + 500), 5, 4), 0);

        // R6: lookup while busy is ignored
        @(negedge clk); lookup_valid = 1'b1; lookup_addr = mk(20'h777, 20, 0);
        @(negedge clk); lookup_valid = 1'b1; lookup_addr = mk(20'h778, 20, 0);
        @(negedge clk); lookup_valid = 1'b0;
        chk(hit_valid == 1'b0, "R6 busy lookup ignored", hit_valid, 0);
        chk(refill_addr == mk(20'h777, 20, 0), "R6 pending kept", refill_addr, mk(20'h777, 20, 0));
        refill_done = 1'b1;
        @(negedge clk); refill_done = 1'b0;
        m_tag[20][m_victim(20)] = 20'h777; begin int v; v = m_victim(20); m_val[20][v] = 1'b1; m_touch(20, v); end
        lookup(mk(20'h777, 20, 8), 0);
        lookup(mk(20'h778, 20, 8), 0);

        // R8: fill set 9, lock ways 0..3, thrash, locked blocks survive
        for (int k = 0; k < 8; k++) lookup(mk(20'(k + 900), 9, 0), 0);
        for (int w = 0; w < 4; w++) maint(2'd1, mk(20'd0, 9, 0), 2'(w));
        for (int k = 0; k < 10; k++) begin
            lookup(mk(20'(k + 1200), 9, 0), 0);
            chk(refill_way[3:0] == 4'd0 || hit, "R8 victim upper half", refill_way, 8'hF0);
        end
        for (int w = 0; w < 4; w++) lookup(mk(m_tag[9][w], 9, 2), 0);
        // R9: unlock all, victims follow the plain tree again
        for (int w = 0; w < 4; w++) maint(2'd2, mk(20'd0, 9, 0), 2'(w));
        for (int k = 0; k < 6; k++) lookup(mk(20'(k + 1400), 9, 0), 0);

        // R10: invalidate one block, neighbour survives, absent tag harmless
        lookup(mk(20'h31, 33, 0), 0);
        lookup(mk(20'h32, 33, 0), 0);
        maint(2'd0, mk(20'h31, 33, 5), 2'd0);
        maint(2'd0, mk(20'h99, 33, 0), 2'd0);
        chk(m_find(33, 20'h31) < 0, "R10 model invalid", 0, 0);
        lookup(mk(20'h32, 33, 1), 0);
        lookup(mk(20'h31, 33, 1), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule